// File: doc/BRIEF.md
# Read-Data Sampling Delay Calibrator

This block chooses the input sampling delay used to capture serial read data. Once `start_i` is pulsed, it steps a 2-bit delay code through four settings, lowest first. Each setting is 2 ns longer than the one before it, so the four settings cover 0 to 6 ns. For each setting the block raises a read request and waits for the acknowledge. It then compares the returned word with the expected pattern and records the outcome in one bit of a pass mask.

After the fourth trial the block turns the pass mask into one final code and sets `done_o`. If the passing settings do not form one unbroken run, or if no setting passed, it also sets `err_o`. The block does not contain the delay line. `dly_code_o` is meant to drive it.

Top module: `rx_delay_cal`

## Requirements
- R1: After reset, `dly_code_o` is 0 and `done_o`, `err_o` and `rd_req_o` are all low.
- R2: A calibration tries codes 0, 1, 2 and 3 in that order. During each trial `dly_code_o` shows the code under test, and the code moves to the next value on the acknowledge of the current trial.
- R3: A trial passes when `rd_data_i` equals `exp_pat_i` in the cycle where `rd_ack_i` is high. A pass sets bit N of the pass mask, where N is the code under test. Exactly four acknowledged reads are consumed per calibration.
- R4: If exactly one code passes, that code is the result.
- R5: If two adjacent codes pass, the result is 0 for {0,1}, 1 for {1,2} and 3 for {2,3}.
- R6: If three adjacent codes pass, the middle one is the result: 1 for {0,1,2} and 2 for {1,2,3}.
- R7: If all four codes pass, the result is 1.
- R8: If no code passes, or the passing codes have a gap, `err_o` rises together with `done_o` and `dly_code_o` returns to 0.
- R9: `err_o` is never high unless `done_o` is high.
- R10: A `start_i` pulse while a calibration is running has no effect. The result, the number of reads and the final state are the same as without that pulse.
- R11: An accepted `start_i` clears `done_o` and `err_o` in the cycle that follows.
- R12: Once `done_o` is high, `dly_code_o` and `done_o` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration (accepted only when idle) |
| exp_pat_i | input | 16 | Pattern a correct test read returns |
| rd_req_o | output | 1 | Test read request, held until acknowledged |
| rd_ack_i | input | 1 | One-cycle acknowledge of the test read |
| rd_data_i | input | 16 | Read data, valid with `rd_ack_i` |
| dly_code_o | output | 2 | Trial code while running, selected code afterwards |
| done_o | output | 1 | Calibration finished |
| err_o | output | 1 | Passing codes empty or not contiguous |

## Verification
Two events can land in the same clock cycle: a new start request and the acknowledge of the final trial read. The bench provokes this by having its read responder raise `start_i` in the exact cycle it returns the fourth acknowledge. It also sends a separate start pulse in the middle of a calibration. In both cases the bench checks that the selected code matches the mask it presented, that only four reads were served, and that `done_o` stays high afterwards, which shows the pulse neither restarted nor disturbed the run.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;

   typedef enum logic [1:0] {
      CAL_IDLE = 2'd0,
      CAL_TRY  = 2'd1,
      CAL_PICK = 2'd2
   } cal_state_e;

   localparam int unsigned CAL_SETTINGS = 4;

endpackage

// File: rtl/dlycal_match.sv
module dlycal_match #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [DATA_W-1:0] ref_i,
   output logic              hit_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("dlycal_match: DATA_W must be at least 1");
   end

   assign hit_o = (word_i == ref_i);

endmodule

// File: rtl/dlycal_picker.sv
module dlycal_picker #(
   parameter int unsigned SETTINGS = 4,
   localparam int unsigned CW      = $clog2(SETTINGS)
) (
   input  logic [SETTINGS-1:0] mask_i,
   output logic [CW-1:0]       code_o,
   output logic                bad_o
);

   if (SETTINGS != 4) begin : g_bad_settings
      $error("dlycal_picker: selection rule defined for four settings only");
   end

   logic [CW-1:0]     low_idx;
   logic              seen;
   logic [CW:0]       n_pass;
   logic [SETTINGS:0] shifted;
   logic [SETTINGS:0] run_ref;

   always_comb begin
      low_idx = '0;
      seen    = 1'b0;
      n_pass  = '0;
      for (int i = 0; i < SETTINGS; i++) begin
         if (mask_i[i]) begin
            n_pass = n_pass + 1'b1;
            if (!seen) begin
               low_idx = CW'(i);
               seen    = 1'b1;
            end
         end
      end
   end

   // A passing set is acceptable only if it is one unbroken run from low_idx
   always_comb begin
      shifted = {1'b0, mask_i} >> low_idx;
      run_ref = ({{SETTINGS{1'b0}}, 1'b1} << n_pass) - 1'b1;
      bad_o   = (n_pass == '0) || (shifted != run_ref);
   end

   always_comb begin
      code_o = '0;
      if (!bad_o) begin
         case (n_pass)
            (CW+1)'(1): code_o = low_idx;
            (CW+1)'(2): begin
               if (low_idx == CW'(0))      code_o = CW'(0);
               else if (low_idx == CW'(1)) code_o = CW'(1);
               else                        code_o = CW'(3);
            end
            (CW+1)'(3): code_o = low_idx + CW'(1);
            default:    code_o = CW'(1);
         endcase
      end
   end

endmodule

// File: rtl/rx_delay_cal.sv
module rx_delay_cal #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_CODES = 4,
   localparam int unsigned CODE_W   = $clog2(NUM_CODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] exp_pat_i,
   output logic              rd_req_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [CODE_W-1:0] dly_code_o,
   output logic              done_o,
   output logic              err_o
);
   import dlycal_pkg::*;

   if (NUM_CODES != CAL_SETTINGS) begin : g_bad_codes
      $error("rx_delay_cal: NUM_CODES must equal CAL_SETTINGS");
   end

   localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_CODES - 1);

   cal_state_e           state;
   logic [CODE_W-1:0]    trial;
   logic [CODE_W-1:0]    final_code;
   logic [NUM_CODES-1:0] pass_mask;
   logic                 word_hit;
   logic [CODE_W-1:0]    sel_code;
   logic                 sel_bad;
   logic                 take_start;
   logic                 trial_end;

   assign take_start = start_i && (state == CAL_IDLE);
   assign trial_end  = (state == CAL_TRY) && rd_ack_i;

   dlycal_match #(.DATA_W(DATA_W)) u_match (
      .word_i (rd_data_i),
      .ref_i  (exp_pat_i),
      .hit_o  (word_hit)
   );

   dlycal_picker #(.SETTINGS(NUM_CODES)) u_picker (
      .mask_i (pass_mask),
      .code_o (sel_code),
      .bad_o  (sel_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CAL_IDLE;
         trial <= '0;
      end else begin
         case (state)
            CAL_IDLE: if (take_start) begin
               state <= CAL_TRY;
               trial <= '0;
            end
            CAL_TRY: if (rd_ack_i) begin
               if (trial == LAST_CODE) state <= CAL_PICK;
               else                    trial <= trial + 1'b1;
            end
            default: state <= CAL_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       pass_mask[g] <= 1'b0;
         else if (take_start)                              pass_mask[g] <= 1'b0;
         else if (trial_end && (trial == CODE_W'(g)))      pass_mask[g] <= word_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         final_code <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
      end else if (take_start) begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else if (state == CAL_PICK) begin
         final_code <= sel_code;
         done_o     <= 1'b1;
         err_o      <= sel_bad;
      end
   end

   assign rd_req_o   = (state == CAL_TRY);
   assign dly_code_o = (state == CAL_TRY) ? trial : final_code;

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ack_i && dly_code_o != LAST_CODE)
      |=> (rd_req_o && dly_code_o == CODE_W'($past(dly_code_o) + 1'b1)));

   p_pick_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAL_PICK && !sel_bad) |=> pass_mask[dly_code_o]);

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && start_i && !rd_ack_i) |=> (rd_req_o && $stable(dly_code_o)));

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take_start |=> (!done_o && !err_o));

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(dly_code_o)));

endmodule

// File: tb/rx_delay_cal_bench.sv
module rx_delay_cal_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_main = 1'b0;
   logic        start_poke = 1'b0;
   logic        start_i;
   logic [15:0] exp_pat_i = 16'h5AA5;
   logic        rd_req_o;
   logic        rd_ack_i = 1'b0;
   logic [15:0] rd_data_i = 16'h0000;
   logic [1:0]  dly_code_o;
   logic        done_o;
   logic        err_o;

   assign start_i = start_main | start_poke;

   always #10 clk = ~clk;

   rx_delay_cal u_rx_delay_cal (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .exp_pat_i  (exp_pat_i),
      .rd_req_o   (rd_req_o),
      .rd_ack_i   (rd_ack_i),
      .rd_data_i  (rd_data_i),
      .dly_code_o (dly_code_o),
      .done_o     (done_o),
      .err_o      (err_o)
   );

   // {err, code} expected for each pass mask 0..15 (bit N = code N passes)
   localparam logic [2:0] EXPECT [16] = '{
      3'b100, 3'b000, 3'b001, 3'b000, 3'b010, 3'b100, 3'b001, 3'b001,
      3'b011, 3'b100, 3'b100, 3'b100, 3'b011, 3'b100, 3'b010, 3'b001};

   int   n_checks = 0;
   int   n_fails  = 0;
   int   acks     = 0;
   int   lat      = 0;
   int   wait_cnt = 0;
   int   cycles   = 0;
   logic [3:0] cur_mask = 4'h0;
   bit   poke_last = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   // Read responder: acknowledges each request after lat idle cycles
   initial begin
      forever begin
         @(negedge clk);
         start_poke = 1'b0;
         if (rd_ack_i) begin
            rd_ack_i = 1'b0;
         end else if (rd_req_o) begin
            if (wait_cnt >= lat) begin
               // R2: trial order follows the count of served reads
               chk(dly_code_o == 2'(acks), "R2 trial code", dly_code_o, acks);
               rd_data_i = cur_mask[dly_code_o] ? exp_pat_i : ~exp_pat_i;
               rd_ack_i  = 1'b1;
               acks++;
               wait_cnt  = 0;
               if (poke_last && acks == 4) start_poke = 1'b1;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   task automatic run_cal(input logic [3:0] m, input int latency, input string tag);
      int guard;
      cur_mask = m;
      lat      = latency;
      acks     = 0;
      wait_cnt = 0;
      @(negedge clk);
      start_main = 1'b1;
      @(negedge clk);
      start_main = 1'b0;
      chk(!done_o && !err_o, "R11 clear on start", {done_o, err_o}, 0);
      guard = 0;
      while (!done_o && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk(done_o, "R3 done reached", done_o, 1);
      chk(acks == 4, "R3 read count", acks, 4);
      chk({err_o, dly_code_o} == EXPECT[m], tag, {err_o, dly_code_o}, EXPECT[m]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dly_code_o == 2'd0 && !done_o && !err_o && !rd_req_o, "R1 reset",
          {rd_req_o, done_o, err_o, dly_code_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_req_o && !done_o, "R1 idle after reset", {rd_req_o, done_o}, 0);

      // Table of all pass masks: R4 R5 R6 R7 R8
      for (int i = 0; i < 16; i++) begin
         run_cal(4'(i), i % 3, "R4-R8 mask table");
         chk(!err_o || done_o, "R9 err implies done", err_o, done_o);
      end

      // R12: result holds while idle
      run_cal(4'b0110, 1, "R5 pair 1,2");
      repeat (5) @(negedge clk);
      chk(done_o && dly_code_o == 2'd1, "R12 hold", dly_code_o, 1);

      // R10: start pulse mid-run is ignored
      cur_mask = 4'b1110;
      lat      = 2;
      acks     = 0;
      wait_cnt = 0;
      @(negedge clk);
      start_main = 1'b1;
      @(negedge clk);
      start_main = 1'b0;
      repeat (4) @(negedge clk);
      start_main = 1'b1;
      @(negedge clk);
      start_main = 1'b0;
      repeat (40) @(negedge clk);
      chk(done_o && dly_code_o == 2'd2 && !err_o, "R10 mid-run start", dly_code_o, 2);
      chk(acks == 4, "R10 read count", acks, 4);

      // R10: start coinciding with the final acknowledge
      poke_last = 1'b1;
      run_cal(4'b0111, 0, "R6 triple low");
      poke_last = 1'b0;
      repeat (10) @(negedge clk);
      chk(done_o && acks == 4, "R10 start on last ack", acks, 4);
      chk(dly_code_o == 2'd1, "R10 code after coincidence", dly_code_o, 1);

      // R8: gap after a good run resets code to 0 and flags error
      run_cal(4'b1111, 0, "R7 all pass");
      run_cal(4'b1001, 1, "R8 gap");
      chk(err_o && dly_code_o == 2'd0, "R8 error code", dly_code_o, 0);

      finish_run();
   end

endmodule